// File: doc/BRIEF.md
# Multicycle 16-bit Processor Core

This block is a compact 16-bit processor that steps through a fixed loop: it fetches one word from a 256-word memory, moves the program counter on by one, splits the word into fields, and then executes it. It has four general registers, a status word, a stack pointer that starts at the top of memory, a limit below which the stack may not grow, and a counter of notional clock ticks. Each instruction class adds a fixed number of ticks to this counter. The tick count does not measure hardware cycles.

The memory sits outside the core on a synchronous port: an address is presented in one cycle and its word is returned in the next. Data enters through a valid/ready input port and leaves through a valid/ready output port. When execution stops, the core raises either a halt output or a fault output and keeps it. Arithmetic is done in a separate ALU. The saving and restoring of context on subroutine entry and exit is done by a separate stack sequencer.

Top module: `mc16_core`

## Requirements
- R1: Instruction fields are as follows: opcode in bits 15:11, destination register in bits 10:9, immediate flag in bit 8, source register in bits 7:6, and address/constant in bits 7:0. The word 0x0547 loads 71 into register 2. The word 0x810A jumps to address 10.
- R2: Opcode 0 with bit 8 clear loads the word at the unsigned 8-bit address. With bit 8 set, it loads the 8-bit constant sign-extended to 16 bits. Opcode 1 stores the destination register at the address.
- R3: The program counter advances by one before each instruction executes. Opcode 16 always jumps. Opcodes 17, 18 and 19 jump only when status bit 3 (less), bit 2 (equal) or bit 1 (greater) is set, respectively.
- R4: Opcodes 2, 3, 4 and 5 are add, add-with-carry, subtract and subtract-with-borrow. The second operand is the source register, or the sign-extended constant when bit 8 is set. Status bit 0 receives the carry out of bit 15, or the borrow for subtraction.
- R5: The remaining unary and logic operations are as follows. Opcodes 6 and 7 are AND and XOR. Opcode 8 inverts the register. Opcodes 9 and 11 shift left and right, filling with zero. Opcode 10 shifts left while keeping bit 15. Opcode 12 shifts right while copying bit 15. The four shifts place the bit shifted out in status bit 0. For opcode 10 that bit is bit 14.
- R6: Opcode 13 compares the register with the operand as signed values. It sets exactly one of status bits 3, 2 and 1 and clears the other two. Opcode 14 copies the status word into the register. Opcode 15 copies the register into the status word.
- R7: Loads from memory, stores, calls and returns each add 4 ticks. Reads and writes each add 28. Every other executed instruction adds 1, including the constant load and halt. An instruction that faults adds nothing.
- R8: Opcode 20 writes six words downward from the stack pointer: first the program counter, then registers 0 to 3, then the status word. It then lowers the pointer by 6 and jumps. Opcode 21 reverses this and raises the pointer by 6. A call when the pointer is below limit+6 faults. A return when the pointer is at 256 or above faults.
- R9: Opcode 22 waits for the input handshake and loads the input word into the register. Opcode 23 presents the register on the output, and holds valid and data until ready is seen.
- R10: Opcode 24 stops with halted set. Any opcode above 25 stops with fault set. Both states are permanent until reset, and neither one writes memory.
- R11: After reset, the tick count is 0, the program counter and first fetch address are 0, the stack pointer is 256, and halted and fault are low.
- R12: Opcode 25 changes nothing except the program counter, which advances, and the tick count, which rises by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 8 | Memory word address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after the address |
| in_valid | input | 1 | Input word available |
| in_ready | output | 1 | Core is waiting for an input word |
| in_data | input | 16 | Input word |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer accepts the output word |
| out_data | output | 16 | Output word |
| halted | output | 1 | Stopped by the halt instruction |
| fault | output | 1 | Stopped by an illegal opcode or a stack bound |
| ticks | output | 16 | Accumulated instruction tick cost |

## Verification
The core is driven by several programs:
- Two fixed instruction words, set apart by a gap of no-ops, show that the fields are decoded at the stated bit positions.
- A chain of arithmetic, shift and compare steps, each result written out, tells the carry and borrow rules apart. It also separates the signed compare from the unsigned one and each shift variant from the others.
- A forced status word followed by all three conditional jumps shows that exactly one of them branches.
- A recursive multiply and factorial program, together with a small call/return program, exercises nested context saves. It also exercises input and output stalls, which come from an irregular handshake pattern.
- Runaway recursion, a return on an empty stack and an undefined opcode each reach the fault state, each after a known tick count.

// File: rtl/mc16_pkg.sv
package mc16_pkg;
  localparam int XLEN      = 16;
  localparam int NREG      = 4;
  localparam int CTX_WORDS = 6;

  typedef enum logic [4:0] {
    OP_LOAD  = 5'd0,  OP_STORE = 5'd1,  OP_ADD   = 5'd2,  OP_ADDC  = 5'd3,
    OP_SUB   = 5'd4,  OP_SUBC  = 5'd5,  OP_AND   = 5'd6,  OP_XOR   = 5'd7,
    OP_NOT   = 5'd8,  OP_SHL   = 5'd9,  OP_SHLA  = 5'd10, OP_SHR   = 5'd11,
    OP_SHRA  = 5'd12, OP_CMP   = 5'd13, OP_GETST = 5'd14, OP_PUTST = 5'd15,
    OP_JMP   = 5'd16, OP_JL    = 5'd17, OP_JE    = 5'd18, OP_JG    = 5'd19,
    OP_CALL  = 5'd20, OP_RET   = 5'd21, OP_IN    = 5'd22, OP_OUT   = 5'd23,
    OP_HALT  = 5'd24, OP_NOP   = 5'd25
  } opcode_e;

  localparam int FL_C = 0;
  localparam int FL_G = 1;
  localparam int FL_E = 2;
  localparam int FL_L = 3;

  localparam logic [XLEN-1:0] TK_BASE = 16'd1;
  localparam logic [XLEN-1:0] TK_MEM  = 16'd4;
  localparam logic [XLEN-1:0] TK_IO   = 16'd28;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DEC, ST_EXEC, ST_LDW, ST_STK, ST_IN, ST_OUT, ST_HALT, ST_ERR
  } state_e;
endpackage

// File: rtl/mc16_alu.sv
module mc16_alu
  import mc16_pkg::*;
(
  input  logic [4:0]      op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            cin,
  output logic [XLEN-1:0] y,
  output logic            cout,
  output logic            lt,
  output logic            eq,
  output logic            gt
);
  logic [XLEN:0] sum, dif;

  always_comb begin
    sum  = {1'b0, a} + {1'b0, b} + {{XLEN{1'b0}}, (op == OP_ADDC) & cin};
    dif  = {1'b0, a} - {1'b0, b} - {{XLEN{1'b0}}, (op == OP_SUBC) & cin};
    y    = a;
    cout = cin;
    case (op)
      OP_ADD, OP_ADDC: begin y = sum[XLEN-1:0]; cout = sum[XLEN]; end
      OP_SUB, OP_SUBC: begin y = dif[XLEN-1:0]; cout = dif[XLEN]; end
      OP_AND:  y = a & b;
      OP_XOR:  y = a ^ b;
      OP_NOT:  y = ~a;
      OP_SHL:  begin y = {a[XLEN-2:0], 1'b0}; cout = a[XLEN-1]; end
      OP_SHLA: begin y = {a[XLEN-1], a[XLEN-3:0], 1'b0}; cout = a[XLEN-2]; end
      OP_SHR:  begin y = {1'b0, a[XLEN-1:1]}; cout = a[0]; end
      OP_SHRA: begin y = {a[XLEN-1], a[XLEN-1:1]}; cout = a[0]; end
      default: ;
    endcase
    lt = $signed(a) < $signed(b);
    eq = (a == b);
    gt = $signed(a) > $signed(b);
  end
endmodule

// File: rtl/mc16_stack_seq.sv
module mc16_stack_seq #(
  parameter int SPW   = 9,
  parameter int DEPTH = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic                       pop,
  input  logic [SPW-1:0]             sp,
  output logic                       busy,
  output logic [SPW-1:0]             addr,
  output logic                       wr,
  output logic [$clog2(DEPTH)-1:0]   slot,
  output logic                       cap,
  output logic [$clog2(DEPTH)-1:0]   cap_slot,
  output logic                       done
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int SW = $clog2(DEPTH);

  logic [CW-1:0]  cnt;
  logic           run, is_pop;
  logic [SPW-1:0] sp_q;
  logic           issue;

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0; cnt <= '0; is_pop <= 1'b0; sp_q <= '0;
    end else if (start) begin
      run <= 1'b1; cnt <= '0; is_pop <= pop; sp_q <= sp;
    end else if (run) begin
      if (done) begin run <= 1'b0; cnt <= '0; end
      else cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    issue    = run && (cnt < CW'(DEPTH));
    done     = run && (cnt == (is_pop ? CW'(DEPTH) : CW'(DEPTH - 1)));
    busy     = run;
    wr       = issue && !is_pop;
    slot     = SW'(cnt);
    cap      = run && is_pop && (cnt != '0);
    cap_slot = SW'(cnt - 1'b1);
    addr     = is_pop ? (sp_q + SPW'(DEPTH - 1) - SPW'(cnt))
                      : (sp_q - SPW'(1) - SPW'(cnt));
  end
endmodule

// File: rtl/mc16_core.sv
module mc16_core
  import mc16_pkg::*;
#(
  parameter int LIMIT_INIT = 36,
  parameter int MEM_WORDS  = 256
) (
  input  logic                          clk,
  input  logic                          rst,
  output logic [$clog2(MEM_WORDS)-1:0]  mem_addr,
  output logic                          mem_we,
  output logic [15:0]                   mem_wdata,
  input  logic [15:0]                   mem_rdata,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [15:0]                   in_data,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [15:0]                   out_data,
  output logic                          halted,
  output logic                          fault,
  output logic [15:0]                   ticks
);
  localparam int AW  = $clog2(MEM_WORDS);
  localparam int SPW = AW + 1;
  localparam int SLW = $clog2(CTX_WORDS);

  state_e          state;
  logic [XLEN-1:0] rf [NREG];
  logic [AW-1:0]   pc;
  logic [XLEN-1:0] ir, sr, ticks_q, out_q;
  logic [SPW-1:0]  sp;

  logic [4:0]      op;
  logic [1:0]      rd, rs;
  logic            imm;
  logic [AW-1:0]   a8;
  logic [XLEN-1:0] sx, opb, alu_y, cost;
  logic            alu_c, c_lt, c_eq, c_gt;
  logic            stk_full, stk_empty, op_bad, seq_start;
  logic            seq_busy, seq_wr, seq_cap, seq_done;
  logic [SPW-1:0]  seq_addr;
  logic [SLW-1:0]  seq_slot, seq_cslot;

  assign op        = ir[15:11];
  assign rd        = ir[10:9];
  assign imm       = ir[8];
  assign rs        = ir[7:6];
  assign a8        = AW'(ir[7:0]);
  assign sx        = {{(XLEN-8){ir[7]}}, ir[7:0]};
  assign opb       = imm ? sx : rf[rs];
  assign stk_full  = sp < SPW'(LIMIT_INIT + CTX_WORDS);
  assign stk_empty = sp >= SPW'(MEM_WORDS);
  assign op_bad    = op > OP_NOP;
  assign seq_start = (state == ST_EXEC) &&
                     ((op == OP_CALL && !stk_full) || (op == OP_RET && !stk_empty));

  always_comb begin
    case (op)
      OP_LOAD:                   cost = imm ? TK_BASE : TK_MEM;
      OP_STORE, OP_CALL, OP_RET: cost = TK_MEM;
      OP_IN, OP_OUT:             cost = TK_IO;
      default:                   cost = TK_BASE;
    endcase
  end

  mc16_alu u_alu (
    .op(op), .a(rf[rd]), .b(opb), .cin(sr[FL_C]),
    .y(alu_y), .cout(alu_c), .lt(c_lt), .eq(c_eq), .gt(c_gt)
  );

  mc16_stack_seq #(.SPW(SPW), .DEPTH(CTX_WORDS)) u_seq (
    .clk(clk), .rst(rst), .start(seq_start), .pop(op == OP_RET), .sp(sp),
    .busy(seq_busy), .addr(seq_addr), .wr(seq_wr), .slot(seq_slot),
    .cap(seq_cap), .cap_slot(seq_cslot), .done(seq_done)
  );

  // memory port: fetch address by default, operand or stack address otherwise
  always_comb begin
    mem_addr  = pc;
    mem_we    = 1'b0;
    mem_wdata = rf[rd];
    if (state == ST_EXEC && (op == OP_LOAD || op == OP_STORE)) begin
      mem_addr = a8;
      mem_we   = (op == OP_STORE);
    end else if (state == ST_STK) begin
      mem_addr = seq_addr[AW-1:0];
      mem_we   = seq_wr;
      if (seq_slot == '0)                    mem_wdata = XLEN'(pc);
      else if (seq_slot == SLW'(CTX_WORDS-1)) mem_wdata = sr;
      else                                    mem_wdata = rf[2'(seq_slot - 1'b1)];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_FETCH;
      pc      <= '0;
      ir      <= '0;
      sr      <= '0;
      sp      <= SPW'(MEM_WORDS);
      ticks_q <= '0;
      out_q   <= '0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      case (state)
        ST_FETCH: state <= ST_DEC;
        ST_DEC: begin
          ir    <= mem_rdata;
          pc    <= pc + 1'b1;
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          if (op_bad || (op == OP_CALL && stk_full) || (op == OP_RET && stk_empty)) begin
            state <= ST_ERR;
          end else begin
            ticks_q <= ticks_q + cost;
            state   <= ST_FETCH;
            case (op)
              OP_LOAD: if (imm) rf[rd] <= sx; else state <= ST_LDW;
              OP_ADD, OP_ADDC, OP_SUB, OP_SUBC,
              OP_SHL, OP_SHLA, OP_SHR, OP_SHRA: begin
                rf[rd]   <= alu_y;
                sr[FL_C] <= alu_c;
              end
              OP_AND, OP_XOR, OP_NOT: rf[rd] <= alu_y;
              OP_CMP: begin
                sr[FL_L] <= c_lt; sr[FL_E] <= c_eq; sr[FL_G] <= c_gt;
              end
              OP_GETST: rf[rd] <= sr;
              OP_PUTST: sr <= rf[rd];
              OP_JMP:   pc <= a8;
              OP_JL:    if (sr[FL_L]) pc <= a8;
              OP_JE:    if (sr[FL_E]) pc <= a8;
              OP_JG:    if (sr[FL_G]) pc <= a8;
              OP_CALL, OP_RET: state <= ST_STK;
              OP_IN:    state <= ST_IN;
              OP_OUT: begin out_q <= rf[rd]; state <= ST_OUT; end
              OP_HALT:  state <= ST_HALT;
              default: ;
            endcase
          end
        end
        ST_LDW: begin
          rf[rd] <= mem_rdata;
          state  <= ST_FETCH;
        end
        ST_STK: begin
          if (seq_cap) begin
            if (seq_cslot == '0)                     pc <= AW'(mem_rdata);
            else if (seq_cslot == SLW'(CTX_WORDS-1))  sr <= mem_rdata;
            else                                      rf[2'(seq_cslot - 1'b1)] <= mem_rdata;
          end
          if (seq_done) begin
            if (op == OP_CALL) begin
              pc <= a8;
              sp <= sp - SPW'(CTX_WORDS);
            end else begin
              sp <= sp + SPW'(CTX_WORDS);
            end
            state <= ST_FETCH;
          end
        end
        ST_IN: if (in_valid) begin
          rf[rd] <= in_data;
          state  <= ST_FETCH;
        end
        ST_OUT: if (out_ready) state <= ST_FETCH;
        default: ;
      endcase
    end
  end

  assign in_ready  = (state == ST_IN);
  assign out_valid = (state == ST_OUT);
  assign out_data  = out_q;
  assign halted    = (state == ST_HALT);
  assign fault     = (state == ST_ERR);
  assign ticks     = ticks_q;
endmodule

// File: rtl/mc16_core_chk.sv
module mc16_core_chk #(
  parameter int MEM_WORDS = 256,
  parameter int SPW       = 9
) (
  input logic           clk,
  input logic           rst,
  input logic           halted,
  input logic           fault,
  input logic           mem_we,
  input logic           in_ready,
  input logic           in_valid,
  input logic           out_valid,
  input logic           out_ready,
  input logic [15:0]    out_data,
  input logic [15:0]    ticks,
  input logic [SPW-1:0] sp
);
  p_stop_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(halted && fault));
  p_halt_hold_r10: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && !mem_we));
  p_fault_hold_r10: assert property (@(posedge clk) disable iff (rst)
    fault |=> (fault && !mem_we));
  p_out_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  p_in_wait_r9: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> in_ready);
  p_sp_step_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(sp) |-> (sp == $past(sp) + SPW'(6) || sp == $past(sp) - SPW'(6)));
  p_tick_step_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(ticks) |-> ((ticks - $past(ticks)) == 16'd1 ||
                         (ticks - $past(ticks)) == 16'd4 ||
                         (ticks - $past(ticks)) == 16'd28));
  p_reset_state_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ticks == 16'd0 && sp == SPW'(MEM_WORDS) && !halted && !fault));
endmodule

bind mc16_core mc16_core_chk #(.MEM_WORDS(MEM_WORDS), .SPW(SPW)) u_chk (
  .clk(clk), .rst(rst), .halted(halted), .fault(fault), .mem_we(mem_we),
  .in_ready(in_ready), .in_valid(in_valid), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .ticks(ticks), .sp(sp)
);

// File: tb/mc16_core_tb_top.sv
module mc16_core_tb_top;
  localparam int LIM = 36;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic [7:0]  mem_addr;
  logic        mem_we;
  logic [15:0] mem_wdata, mem_rdata;
  logic        in_valid = 1'b0, in_ready;
  logic [15:0] in_data = '0;
  logic        out_valid, out_ready = 1'b0;
  logic [15:0] out_data;
  logic        halted, fault;
  logic [15:0] ticks;

  logic [15:0] mem [256];
  logic        ld_en = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;

  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  mc16_core #(.LIMIT_INIT(LIM), .MEM_WORDS(256)) dut_i (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .halted(halted),
    .fault(fault), .ticks(ticks)
  );

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // program and stimulus under construction
  logic [15:0] prog [$];
  logic [15:0] ins [$];
  function automatic void p(input int op, input int rd, input int im, input int lo);
    prog.push_back({op[4:0], rd[1:0], im[0], lo[7:0]});
  endfunction

  // instruction-level reference
  logic [15:0] mm [256];
  logic [15:0] mr [4];
  logic [15:0] msr, mt;
  logic [8:0]  msp;
  logic [7:0]  mpc;
  bit          m_halt, m_err;
  logic [15:0] exp_out [$];

  task automatic model();
    logic [15:0] w, b, c, ctx [6];
    logic [16:0] t;
    logic [15:0] in_m [$];
    int op, rd, rs;
    bit im;
    logic [7:0] a8;
    in_m = ins;
    for (int i = 0; i < 256; i++) mm[i] = (i < prog.size()) ? prog[i] : 16'h0;
    for (int i = 0; i < 4; i++) mr[i] = '0;
    msr = '0; mt = '0; msp = 9'd256; mpc = '0; m_halt = 0; m_err = 0;
    exp_out.delete();
    for (int step = 0; step < 20000 && !m_halt && !m_err; step++) begin
      w = mm[mpc]; mpc = mpc + 8'd1;
      op = int'(w[15:11]); rd = int'(w[10:9]); im = w[8]; rs = int'(w[7:6]);
      a8 = w[7:0]; c = {{8{a8[7]}}, a8}; b = im ? c : mr[rs];
      case (op)
        0: if (im) begin mr[rd] = c; mt += 1; end else begin mr[rd] = mm[a8]; mt += 4; end
        1: begin mm[a8] = mr[rd]; mt += 4; end
        2, 3: begin
          t = {1'b0, mr[rd]} + {1'b0, b} + 17'((op == 3) ? msr[0] : 1'b0);
          mr[rd] = t[15:0]; msr[0] = t[16]; mt += 1;
        end
        4, 5: begin
          t = {1'b0, mr[rd]} - {1'b0, b} - 17'((op == 5) ? msr[0] : 1'b0);
          mr[rd] = t[15:0]; msr[0] = t[16]; mt += 1;
        end
        6:  begin mr[rd] = mr[rd] & b; mt += 1; end
        7:  begin mr[rd] = mr[rd] ^ b; mt += 1; end
        8:  begin mr[rd] = ~mr[rd]; mt += 1; end
        9:  begin msr[0] = mr[rd][15]; mr[rd] = mr[rd] << 1; mt += 1; end
        10: begin msr[0] = mr[rd][14]; mr[rd] = {mr[rd][15], mr[rd][13:0], 1'b0}; mt += 1; end
        11: begin msr[0] = mr[rd][0]; mr[rd] = mr[rd] >> 1; mt += 1; end
        12: begin msr[0] = mr[rd][0]; mr[rd] = {mr[rd][15], mr[rd][15:1]}; mt += 1; end
        13: begin
          msr[3] = $signed(mr[rd]) < $signed(b);
          msr[2] = mr[rd] == b;
          msr[1] = $signed(mr[rd]) > $signed(b);
          mt += 1;
        end
        14: begin mr[rd] = msr; mt += 1; end
        15: begin msr = mr[rd]; mt += 1; end
        16: begin mpc = a8; mt += 1; end
        17: begin if (msr[3]) mpc = a8; mt += 1; end
        18: begin if (msr[2]) mpc = a8; mt += 1; end
        19: begin if (msr[1]) mpc = a8; mt += 1; end
        20: if (msp < 9'(LIM + 6)) m_err = 1;
            else begin
              ctx[0] = {8'h0, mpc}; ctx[5] = msr;
              for (int k = 1; k < 5; k++) ctx[k] = mr[k-1];
              for (int k = 0; k < 6; k++) mm[8'(msp - 9'(1 + k))] = ctx[k];
              msp = msp - 9'd6; mpc = a8; mt += 4;
            end
        21: if (msp >= 9'd256) m_err = 1;
            else begin
              for (int k = 0; k < 6; k++) ctx[k] = mm[8'(msp + 9'(5 - k))];
              mpc = ctx[0][7:0]; msr = ctx[5];
              for (int k = 1; k < 5; k++) mr[k-1] = ctx[k];
              msp = msp + 9'd6; mt += 4;
            end
        22: begin mr[rd] = in_m.pop_front(); mt += 28; end
        23: begin exp_out.push_back(mr[rd]); mt += 28; end
        24: begin m_halt = 1; mt += 1; end
        25: mt += 1;
        default: m_err = 1;
      endcase
    end
  endtask

  task automatic run(input string name, input string req);
    logic [15:0] drv [$];
    int bad_words, cyc;
    model();
    drv = ins;
    rst = 1'b1;
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = 8'(a);
      ld_data = (a < prog.size()) ? prog[a] : 16'h0;
    end
    @(negedge clk);
    ld_en = 1'b0;
    // R11: reset state seen at the ports
    chk(!halted && !fault, "R11", {name, " stop flags in reset"}, int'({halted, fault}), 0);
    chk(ticks == 16'd0, "R11", {name, " ticks in reset"}, int'(ticks), 0);
    chk(mem_addr == 8'd0 && !mem_we, "R11", {name, " first fetch address"}, int'(mem_addr), 0);
    rst = 1'b0;
    cyc = 0;
    while (!halted && !fault && cyc < 30000) begin
      @(negedge clk);
      cyc++;
      in_valid = (drv.size() > 0) && (cyc % 5 != 0);
      in_data  = in_valid ? drv[0] : 16'h0;
      if (in_valid && in_ready) void'(drv.pop_front());
      out_ready = (cyc % 3 != 0);
      if (out_valid && out_ready) begin
        if (exp_out.size() == 0) chk(0, "R9", {name, " unexpected output"}, int'(out_data), -1);
        else chk(out_data == exp_out[0], req, {name, " output word"}, int'(out_data), int'(exp_out[0]));
        if (exp_out.size() > 0) void'(exp_out.pop_front());
      end
    end
    in_valid = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(halted == m_halt, "R10", {name, " halted"}, int'(halted), int'(m_halt));
    chk(fault == m_err, "R10", {name, " fault"}, int'(fault), int'(m_err));
    chk(ticks == mt, "R7", {name, " tick count"}, int'(ticks), int'(mt));
    chk(exp_out.size() == 0, "R9", {name, " missing outputs"}, exp_out.size(), 0);
    bad_words = 0;
    for (int a = 0; a < 256; a++) if (mem[a] !== mm[a]) bad_words++;
    chk(bad_words == 0, "R8", {name, " memory image"}, bad_words, 0);
    prog.delete(); ins.delete();
  endtask

  bit finished = 0;
  initial begin
    #2_000_000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 R3: fixed words 0x810A and 0x0547
    prog.push_back(16'h810A);
    for (int i = 0; i < 9; i++) p(25, 0, 0, 0);
    prog.push_back(16'h0547);
    p(23, 2, 0, 0); p(24, 0, 0, 0);
    run("fixed_words", "R1");
    chk(mt == 16'd31, "R1", "fixed_words reference ticks", int'(mt), 31);

    // R4 R5 R6: arithmetic, logic, shifts, compare, status read
    p(0,0,1,-1); p(0,1,1,1); p(2,0,0,1<<6); p(23,0,0,0);
    p(3,1,1,5); p(23,1,0,0); p(0,2,1,3); p(4,2,0,1<<6); p(23,2,0,0);
    p(5,2,1,1); p(23,2,0,0); p(14,3,0,0); p(23,3,0,0);
    p(0,3,1,8'h55); p(6,3,1,15); p(7,3,0,2<<6); p(23,3,0,0); p(8,3,0,0); p(23,3,0,0);
    p(0,0,1,-128); p(9,0,0,0); p(23,0,0,0); p(14,1,0,0); p(23,1,0,0);
    p(0,0,1,8'h60); p(10,0,0,0); p(23,0,0,0); p(14,1,0,0); p(23,1,0,0);
    p(0,0,1,-127); p(11,0,0,0); p(23,0,0,0); p(0,0,1,-127); p(12,0,0,0); p(23,0,0,0);
    p(14,1,0,0); p(23,1,0,0);
    p(0,0,1,-2); p(13,0,1,5); p(14,1,0,0); p(23,1,0,0);
    p(13,0,1,-2); p(14,1,0,0); p(23,1,0,0);
    p(0,2,1,3); p(13,2,0,0); p(14,1,0,0); p(23,1,0,0);
    p(24,0,0,0);
    run("alu_chain", "R4");

    // R3 R6 R12: forced status, conditional jumps, no-op
    p(0,0,1,4); p(15,0,0,0); p(17,0,1,9); p(19,0,1,9); p(18,0,1,6);
    p(24,0,0,0); p(25,0,0,0); p(14,1,0,0); p(23,1,0,0); p(24,0,0,0);
    run("branch_status", "R3");

    // R2: memory load/store and constant sign extension
    p(0,1,1,-3); p(1,1,0,100); p(0,2,0,100); p(23,2,0,0); p(0,3,0,20); p(23,3,0,0);
    p(24,0,0,0);
    while (prog.size() < 20) p(25,0,0,0);
    prog.push_back(16'h1234);
    run("load_store", "R2");

    // R8 R9: call/return with input and output
    p(22,0,0,0); p(20,0,1,5); p(0,0,0,8); p(23,0,0,0); p(24,0,0,0);
    p(2,0,1,5); p(1,0,0,8); p(21,0,0,0); p(25,0,0,0);
    ins.push_back(16'd10);
    run("add5", "R8");

    // R8 R9: recursive factorial with shift-add multiply
    p(0,0,1,1); p(22,1,0,0); p(20,0,1,6); p(0,0,0,33); p(23,0,0,0); p(24,0,0,0);
    p(13,1,1,1); p(18,0,1,14); p(17,0,1,14); p(20,0,1,16); p(0,0,0,34); p(4,1,1,1);
    p(20,0,1,6); p(0,0,0,33); p(1,0,0,33); p(21,0,0,0);
    p(0,2,1,8); p(0,3,1,0); p(11,1,0,0); p(1,2,0,35); p(14,2,0,0); p(6,2,1,1);
    p(13,2,1,1); p(18,0,1,25); p(16,0,1,26); p(2,3,0,0); p(9,0,0,0); p(0,2,0,35);
    p(4,2,1,1); p(13,2,1,0); p(19,0,1,18); p(1,3,0,34); p(21,0,0,0);
    p(25,0,0,0); p(25,0,0,0); p(25,0,0,0);
    ins.push_back(16'd5);
    run("factorial", "R8");

    // R9: read then write with stalls
    p(22,0,0,0); p(0,1,1,-2); p(2,0,0,1<<6); p(23,0,0,0); p(24,0,0,0);
    ins.push_back(16'd7);
    run("io_sub2", "R9");

    // R8: runaway recursion reaches the stack bound
    p(20,0,1,0);
    run("stack_full", "R8");
    chk(mt == 16'd144, "R8", "stack_full reference ticks", int'(mt), 144);

    // R8: return with nothing saved
    p(21,0,0,0);
    run("stack_empty", "R8");

    // R10: undefined opcode after a no-op
    p(25,0,0,0); p(26,0,0,0); p(25,0,0,0);
    run("bad_opcode", "R10");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule